// File: doc/BRIEF.md
# Cascadable Serial Result Readout Port

This block is the digital side of a converter's serial slave port. Each finished conversion arrives as a parallel word with a one-cycle done strobe. The block keeps that word in a holding register. An external host then clocks the word out, most significant bit first, on its own serial clock, while both an active-low select and an active-low read strobe are held low. The serial clock and the serial data input are brought into the system clock domain through a short synchroniser. All state in the block runs on the system clock.

Two read modes are provided. In the after-conversion mode the host reads once busy has dropped, and may carry on reading after the next conversion has started. In the during-conversion mode the host reads the previous word while the next conversion runs, and a read-error pulse flags a read that is still open when that conversion finishes. In the after-conversion mode, a serial data input is sampled on the clock edge opposite the shift edge and enters the shift register behind the local word. Several ports can therefore be chained, and the upstream words then follow the local LSB on the output.

Top module: `adc_serial_port`

## Requirements
- R1: The word is WORD_W (default 18) bits wide. With the port selected, `sdo_o` shows bit WORD_W-1 before any shift edge, and bit WORD_W-1-k after k shift edges, for k from 0 to WORD_W-1.
- R2: `sdo_oe_o` is 1 only while `cs_ni` and `rd_ni` are both 0. Serial clock edges seen while either strobe is 1 do not advance the word.
- R3: Raising `cs_ni` or `rd_ni` and lowering both again restarts the read at the MSB of the held word.
- R4: `busy_o` is 1 from the cycle after `conv_start_i` until the cycle after `conv_done_i`. The value of `result_i` at the `conv_done_i` cycle becomes the held word.
- R5: A finished conversion does not disturb a read that has already shifted at least one bit. The remaining bits come from the old word, and the next fresh read returns the new word.
- R6: With `mode_dur_i`=0, `sdi_i` is captured on the edge opposite the shift edge and shifted in behind the local word. In a two-port chain, 2*WORD_W pulses return the downstream word and then the upstream word, each MSB first.
- R7: With `sclk_inv_i`=0 the shift edge is the rising edge of `sclk_i` and capture is on the falling edge. With `sclk_inv_i`=1 both edges swap, and the bit order is unchanged.
- R8: With `mode_dur_i`=1, `sdi_i` is ignored and zeros are shifted in behind the local word.
- R9: With `mode_dur_i`=1, a `conv_done_i` that arrives while the port is selected with fewer than WORD_W shift edges taken gives a `rd_err_o` pulse exactly one system cycle wide, in the next cycle. A complete read, or the mode `mode_dur_i`=0, gives no pulse.
- R10: After reset, `busy_o`, `sdo_oe_o` and `rd_err_o` are 0, and a read taken before any conversion returns all zeros.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Active-low synchronous reset |
| conv_start_i | input | 1 | One-cycle pulse: conversion begins |
| conv_done_i | input | 1 | One-cycle pulse: conversion result valid |
| result_i | input | WORD_W | Parallel conversion result |
| mode_dur_i | input | 1 | 0 = read after conversion, 1 = read during conversion |
| cs_ni | input | 1 | Active-low select |
| rd_ni | input | 1 | Active-low read strobe |
| sclk_i | input | 1 | Host serial clock |
| sclk_inv_i | input | 1 | Serial clock polarity select |
| sdi_i | input | 1 | Cascade data from the upstream port |
| sdo_o | output | 1 | Serial data out |
| sdo_oe_o | output | 1 | Output enable for the serial data pad |
| busy_o | output | 1 | Conversion in progress |
| rd_err_o | output | 1 | One-cycle incomplete-read pulse |

## Verification
The bench builds two ports with the default 18-bit word and a two-stage synchroniser, and chains the upstream output into the downstream cascade input. With an 18-bit word, every single-bit position can be walked through a complete 36-pulse chain read, along with a set of arithmetic patterns and their complements. The same small configuration also allows reads to be cut short at chosen bit counts, so the restart, the read carried across a conversion and the error pulse can each be aimed at a known bit index. Both clock polarities and both read modes are used.

// File: rtl/adc_rd_pkg.sv
package adc_rd_pkg;

  // Saturating increment of a bit count held in an integer.
  function automatic int unsigned cnt_next(input int unsigned cur, input int unsigned top);
    return (cur >= top) ? top : cur + 1;
  endfunction

  // A read is complete once a whole word has been shifted.
  function automatic bit word_read(input int unsigned cnt, input int unsigned word_w);
    return cnt >= word_w;
  endfunction

endpackage

// File: rtl/sclk_sync.sv
module sclk_sync #(
  parameter int unsigned SYNC = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic sclk_i,
  input  logic inv_i,
  input  logic sdi_i,
  output logic rise_o,
  output logic fall_o,
  output logic sdi_o
);
  // sk_q[SYNC] is one cycle older than sk_q[SYNC-1]; data is aligned to sk_q[SYNC-1]
  logic [SYNC:0]   sk_q;
  logic [SYNC-1:0] sd_q;

  always_ff @(posedge clk_i) begin
    if (!rst_ni) begin
      sk_q <= '0;
      sd_q <= '0;
    end else begin
      sk_q <= {sk_q[SYNC-1:0], sclk_i ^ inv_i};
      sd_q <= {sd_q[SYNC-2:0], sdi_i};
    end
  end

  assign rise_o = sk_q[SYNC-1] & ~sk_q[SYNC];
  assign fall_o = ~sk_q[SYNC-1] & sk_q[SYNC];
  assign sdi_o  = sd_q[SYNC-1];
endmodule

// File: rtl/rd_shifter.sv
module rd_shifter
  import adc_rd_pkg::*;
#(
  parameter int unsigned W     = 18,
  parameter int unsigned CNT_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             active_i,
  input  logic             mode_dur_i,
  input  logic             rise_i,
  input  logic             fall_i,
  input  logic             sdi_i,
  input  logic [W-1:0]     hold_i,
  output logic             sdo_o,
  output logic [CNT_W-1:0] cnt_o
);
  localparam int unsigned CNT_TOP = (1 << CNT_W) - 1;

  logic [W-1:0]     sr_q;
  logic             cap_q;
  logic [CNT_W-1:0] cnt_q;
  logic             shift_ev;
  logic             idle_ld;

  assign shift_ev = active_i && rise_i;
  assign idle_ld  = (cnt_q == '0);

  always_ff @(posedge clk_i) begin
    if (!rst_ni) begin
      sr_q  <= '0;
      cap_q <= 1'b0;
      cnt_q <= '0;
    end else begin
      // capture edge: opposite to the shift edge; cascade input only in after-mode
      if (active_i && fall_i) cap_q <= mode_dur_i ? 1'b0 : sdi_i;
      if (!active_i)     cnt_q <= '0;
      else if (rise_i)   cnt_q <= CNT_W'(cnt_next(int'(cnt_q), CNT_TOP));
      // reload only when no bit of the current read has left
      if (shift_ev)      sr_q <= {sr_q[W-2:0], cap_q};
      else if (idle_ld)  sr_q <= hold_i;
    end
  end

  assign sdo_o = sr_q[W-1];
  assign cnt_o = cnt_q;

  assert_read_hold_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (active_i && cnt_q != '0 && !rise_i) |=> $stable(sr_q));

  assert_count_step_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (active_i && rise_i && cnt_q != '1) |=> (cnt_q == $past(cnt_q) + 1'b1));

  assert_restart_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !active_i |=> (cnt_q == '0));
endmodule

// File: rtl/conv_tracker.sv
module conv_tracker #(
  parameter int unsigned W = 18
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         conv_start_i,
  input  logic         conv_done_i,
  input  logic [W-1:0] result_i,
  input  logic         mode_dur_i,
  input  logic         active_i,
  input  logic         read_full_i,
  output logic         busy_o,
  output logic [W-1:0] hold_o,
  output logic         rd_err_o
);
  logic         busy_q;
  logic [W-1:0] hold_q;
  logic         rd_err_q;
  logic         open_read;

  // selected but the word not yet fully shifted
  assign open_read = active_i && !read_full_i;

  always_ff @(posedge clk_i) begin
    if (!rst_ni) begin
      busy_q   <= 1'b0;
      hold_q   <= '0;
      rd_err_q <= 1'b0;
    end else begin
      if (conv_start_i)     busy_q <= 1'b1;
      else if (conv_done_i) busy_q <= 1'b0;
      if (conv_done_i)      hold_q <= result_i;
      rd_err_q <= conv_done_i && mode_dur_i && open_read;
    end
  end

  assign busy_o   = busy_q;
  assign hold_o   = hold_q;
  assign rd_err_o = rd_err_q;

  assert_busy_set_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    conv_start_i |=> busy_q);

  assert_err_width_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_err_q |=> !rd_err_q);

  assert_err_mode_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_err_q |-> $past(mode_dur_i));
endmodule

// File: rtl/adc_serial_port.sv
module adc_serial_port
  import adc_rd_pkg::*;
#(
  parameter int unsigned WORD_W = 18,
  parameter int unsigned SYNC   = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              conv_start_i,
  input  logic              conv_done_i,
  input  logic [WORD_W-1:0] result_i,
  input  logic              mode_dur_i,
  input  logic              cs_ni,
  input  logic              rd_ni,
  input  logic              sclk_i,
  input  logic              sclk_inv_i,
  input  logic              sdi_i,
  output logic              sdo_o,
  output logic              sdo_oe_o,
  output logic              busy_o,
  output logic              rd_err_o
);
  localparam int unsigned CNT_W = $clog2(WORD_W * 8);

  logic              active;
  logic              rise_ev;
  logic              fall_ev;
  logic              sdi_sync;
  logic [WORD_W-1:0] hold_w;
  logic [CNT_W-1:0]  cnt_w;
  logic              read_full;

  assign active    = !cs_ni && !rd_ni;
  assign read_full = word_read(int'(cnt_w), WORD_W);

  sclk_sync #(.SYNC(SYNC)) sync_i (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .sclk_i (sclk_i),
    .inv_i  (sclk_inv_i),
    .sdi_i  (sdi_i),
    .rise_o (rise_ev),
    .fall_o (fall_ev),
    .sdi_o  (sdi_sync)
  );

  conv_tracker #(.W(WORD_W)) trk_i (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .conv_start_i (conv_start_i),
    .conv_done_i  (conv_done_i),
    .result_i     (result_i),
    .mode_dur_i   (mode_dur_i),
    .active_i     (active),
    .read_full_i  (read_full),
    .busy_o       (busy_o),
    .hold_o       (hold_w),
    .rd_err_o     (rd_err_o)
  );

  rd_shifter #(.W(WORD_W), .CNT_W(CNT_W)) shf_i (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .active_i   (active),
    .mode_dur_i (mode_dur_i),
    .rise_i     (rise_ev),
    .fall_i     (fall_ev),
    .sdi_i      (sdi_sync),
    .hold_i     (hold_w),
    .sdo_o      (sdo_o),
    .cnt_o      (cnt_w)
  );

  assign sdo_oe_o = active;
endmodule

// File: tb/adc_serial_port_tb.sv
module adc_serial_port_tb_top;
  localparam int CLK_P = 10;
  localparam int W     = 18;
  localparam int HALF  = 4;
  localparam logic [W-1:0] MASK = '1;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0, done = 1'b0, mode = 1'b0;
  logic cs_n = 1'b1, rd_n = 1'b1, sclk = 1'b1, pol = 1'b0;
  logic [W-1:0] dn_res = '0, up_res = '0;
  logic sdo, oe, busy, rd_err;
  logic up_sdo, up_oe, up_busy, up_err;

  int total = 0, bad = 0, err_hi = 0;
  bit finished = 0;

  always #(CLK_P/2) clk = ~clk;
  always @(negedge clk) if (rst_n && rd_err) err_hi++;

  adc_serial_port #(.WORD_W(W)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .conv_start_i(start), .conv_done_i(done),
    .result_i(dn_res), .mode_dur_i(mode), .cs_ni(cs_n), .rd_ni(rd_n),
    .sclk_i(sclk), .sclk_inv_i(pol), .sdi_i(up_sdo),
    .sdo_o(sdo), .sdo_oe_o(oe), .busy_o(busy), .rd_err_o(rd_err));

  adc_serial_port #(.WORD_W(W)) up_i (
    .clk_i(clk), .rst_ni(rst_n), .conv_start_i(start), .conv_done_i(done),
    .result_i(up_res), .mode_dur_i(mode), .cs_ni(cs_n), .rd_ni(rd_n),
    .sclk_i(sclk), .sclk_inv_i(pol), .sdi_i(1'b0),
    .sdo_o(up_sdo), .sdo_oe_o(up_oe), .busy_o(up_busy), .rd_err_o(up_err));

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic select();
    cs_n = 1'b0; rd_n = 1'b0; cyc(HALF);
  endtask

  task automatic deselect();
    cs_n = 1'b1; rd_n = 1'b1; cyc(HALF);
  endtask

  // n pulses; bit sampled before each shift edge, first sample lands in the top position
  task automatic pulses(input int n, output logic [63:0] bits);
    bits = '0;
    for (int k = 0; k < n; k++) begin
      sclk = 1'b0 ^ pol; cyc(HALF);
      bits = {bits[62:0], sdo};
      sclk = 1'b1 ^ pol; cyc(HALF);
    end
  endtask

  task automatic convert(input logic [W-1:0] a, input logic [W-1:0] b, input bit chk_busy);
    dn_res = a; up_res = b;
    start = 1'b1; cyc(1); start = 1'b0;
    if (chk_busy) chk(busy == 1'b1, "R4 busy after start", 64'(busy), 64'd1);
    cyc(3);
    done = 1'b1; cyc(1); done = 1'b0;
    if (chk_busy) chk(busy == 1'b0, "R4 busy after done", 64'(busy), 64'd0);
    cyc(2);
  endtask

  task automatic chain_check(input logic [W-1:0] a, input logic [W-1:0] b, input string tag);
    logic [63:0] got;
    select();
    pulses(2*W, got);
    deselect();
    chk(got[2*W-1:0] == {a, b}, tag, got, 64'({a, b}));
  endtask

  initial begin
    logic [63:0] got, g2;
    logic [W-1:0] a, b;
    int e0;
    cyc(3); rst_n = 1'b1; cyc(1);
    // R10 reset state
    chk(busy == 1'b0, "R10 busy", 64'(busy), 0);
    chk(oe == 1'b0, "R10 oe", 64'(oe), 0);
    chk(rd_err == 1'b0, "R10 rd_err", 64'(rd_err), 0);
    select();
    pulses(W, got);
    deselect();
    chk(got == 0, "R10 empty read", got, 0);

    // R1 R6 walking-one and arithmetic sweep through a two-port chain
    for (int i = 0; i < W; i++) begin
      a = W'(1) << i; b = ~a & MASK;
      convert(a, b, i == 0);
      chain_check(a, b, "R1 R6 walk");
    end
    for (int i = 0; i < 20; i++) begin
      a = W'((i * 32'h1F3A7 + 32'h0B2C5) & 32'h3FFFF);
      b = W'((i * 32'h2D1 + 32'h15A) & 32'h3FFFF);
      convert(a, b, 0);
      chain_check(a, b, "R1 R6 pattern");
    end

    // R2 output enable and strobes
    convert(18'h2A5C3, 18'h1, 0);
    chk(oe == 1'b0, "R2 oe idle", 64'(oe), 0);
    cs_n = 1'b0; rd_n = 1'b1; cyc(HALF);
    chk(oe == 1'b0, "R2 oe rd high", 64'(oe), 0);
    pulses(5, got);
    rd_n = 1'b0; cyc(HALF);
    chk(oe == 1'b1, "R2 oe selected", 64'(oe), 1);
    pulses(W, got);
    deselect();
    chk(got == 64'h2A5C3, "R2 no shift with rd high", got, 64'h2A5C3);

    // R3 abort and restart
    select(); pulses(7, got); deselect();
    select(); pulses(W, got); deselect();
    chk(got == 64'h2A5C3, "R3 restart at MSB", got, 64'h2A5C3);

    // R5 read carried across a conversion (after-mode, no error pulse)
    e0 = err_hi;
    convert(18'h3C0F1, 18'h0, 0);
    select(); pulses(9, got);
    convert(18'h05A5A, 18'h0, 1);
    pulses(9, g2);
    deselect();
    chk({got[8:0], g2[8:0]} == 64'h3C0F1, "R5 old word kept", {got[8:0], g2[8:0]}, 64'h3C0F1);
    chk(err_hi == e0, "R9 no pulse in after-mode", 64'(err_hi), 64'(e0));
    select(); pulses(W, got); deselect();
    chk(got == 64'h05A5A, "R5 new word next read", got, 64'h05A5A);

    // R7 inverted clock polarity
    pol = 1'b1; sclk = 1'b0; cyc(HALF);
    convert(18'h1B3E7, 18'h2C4D5, 0);
    chain_check(18'h1B3E7, 18'h2C4D5, "R7 inverted polarity");
    pol = 1'b0; sclk = 1'b1; cyc(HALF);

    // R8 during-mode ignores cascade input
    mode = 1'b1;
    convert(18'h12345, 18'h3FFFF, 0);
    chain_check(18'h12345, 18'h0, "R8 zeros after LSB");

    // R9 complete read during conversion: no pulse
    e0 = err_hi;
    start = 1'b1; cyc(1); start = 1'b0;
    select(); pulses(W, got);
    chk(got == 64'h12345, "R9 previous word read during conversion", got, 64'h12345);
    dn_res = 18'h0F0F0; done = 1'b1; cyc(1); done = 1'b0; cyc(2);
    deselect();
    chk(err_hi == e0, "R9 no pulse on full read", 64'(err_hi), 64'(e0));

    // R9 incomplete read: exactly one pulse one cycle after done
    start = 1'b1; cyc(1); start = 1'b0;
    select(); pulses(10, got);
    dn_res = 18'h00777; done = 1'b1; cyc(1); done = 1'b0;
    chk(rd_err == 1'b1, "R9 pulse present", 64'(rd_err), 1);
    cyc(1);
    chk(rd_err == 1'b0, "R9 pulse ended", 64'(rd_err), 0);
    cyc(3);
    deselect();
    chk(err_hi == e0 + 1, "R9 pulse width", 64'(err_hi), 64'(e0 + 1));
    chk(got[9:0] == 10'(18'h0F0F0 >> 8), "R9 partial bits", got[9:0], 64'(18'h0F0F0 >> 8));
    mode = 1'b0;

    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog expired act=running exp=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule